// File: doc/BRIEF.md
# Multi-Mode Acquisition Trigger Unit

This block decides the moment at which a data acquisition run begins. Software arms it, picks one of three trigger sources, and then waits. The block answers with a one-cycle start pulse and a sticky "fired" flag. The first source is an asynchronous external pin. It can be set to react to a rising or a falling transition, and it only counts when the pin holds its active level for a minimum number of clock cycles. The second source is a 16-bit digital input bus, compared under a per-bit mask against a programmed pattern. The third source is a stream of acquired samples, each tagged with a channel number. Every channel has its own enable, its own threshold and its own direction of comparison.

After an arm, the unit fires at most once. The flag then stays set until the next arm, so software can poll it. The pulse width filter runs with a default of 50 cycles of a 50 MHz clock, so a glitch shorter than 1 µs never starts an acquisition. Once the filter qualifies a pulse, the start pulse follows one cycle later. For pattern and level sources, the start pulse appears two clock edges after the input that caused it, which is far inside two sample periods.

Top module: `acq_trigger_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, `trig_pulse` and `triggered` read 0 and the unit is disarmed, so no source can fire until `arm` is pulsed.
- R2: A high `arm` at a clock edge arms the unit, clears `triggered` and forces `trig_pulse` low for that edge. A fire condition at the same edge is ignored. Each arm yields at most one `trig_pulse`, which is high for exactly one cycle. `triggered` rises together with that pulse and stays 1 until the next arm.
- R3: With `src_mode` = 0 (external), `ext_fall` = 0 makes a high pin level the active level, and `ext_fall` = 1 makes a low pin level the active level.
- R4: The external pin qualifies only after it has been sampled inactive and then sampled active on MIN_W consecutive clock edges (default 50). A shorter active period is ignored. One active period qualifies at most once, however long it lasts.
- R5: If the pin is first sampled active at edge j and stays active through edge j+MIN_W-1, then `trig_pulse` is high in the cycle after edge j+MIN_W+1.
- R6: With `src_mode` = 1 (pattern), a mask bit of 1 makes the matching `din` bit take part in the compare, and a mask bit of 0 makes it a don't-care. The unit fires when every compared bit equals its `pat_value` bit. An all-zero mask never matches. A `din` value sampled at edge k gives the pulse after edge k+1.
- R7: With `src_mode` = 2 (level), a sample with `smp_valid` = 1 on channel c fires the unit when `lvl_enable[c]` = 1 and the value passes the threshold. With `lvl_above[c]` = 1 the value must be strictly greater than `lvl_thresh[16c+15:16c]` (unsigned); with `lvl_above[c]` = 0 it must be strictly less. Disabled channels and cycles without `smp_valid` are ignored. A sample taken at edge k gives the pulse after edge k+1.
- R8: Only the source chosen by `src_mode` can fire. `src_mode` = 3 disables every source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (50 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | One-cycle arm request from software |
| src_mode | input | 2 | 0 external, 1 pattern, 2 level, 3 off |
| ext_fall | input | 1 | External active level: 0 high, 1 low |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| din | input | 16 | Digital input bus for pattern mode |
| pat_value | input | 16 | Pattern to compare against |
| pat_mask | input | 16 | 1 = bit is compared |
| smp_valid | input | 1 | Sample present this cycle |
| smp_chan | input | 4 | Channel of the sample |
| smp_data | input | 16 | Unsigned sample value |
| lvl_enable | input | 16 | Per-channel level trigger enable |
| lvl_above | input | 16 | Per-channel polarity: 1 above, 0 below |
| lvl_thresh | input | 256 | Per-channel thresholds, channel c at bits 16c+15:16c |
| trig_pulse | output | 1 | One-cycle acquisition start |
| triggered | output | 1 | Sticky fired flag, cleared by arm |

## Verification
Most internal faults in this block show up as a start pulse that is missing, extra or mistimed. An off-by-one in the width counter moves the external pulse by one cycle, or lets a pulse one cycle too short get through. A wrong mask or polarity bit either fires on a sample that should be ignored or misses a real crossing, and this shows two edges after the input. A lost arm state shows as a second pulse within one arm, or as `triggered` not holding. The bench compares both outputs against a behavioural model on every clock, so each of these faults is reported in the cycle where it first appears.

// File: rtl/acq_trig_pkg.sv
// Shared definitions for the acquisition trigger unit.
// Assumes: the mode field is two bits wide and is decoded only by the top.
package acq_trig_pkg;
    typedef enum logic [1:0] {
        SRC_EXT = 2'd0,
        SRC_PAT = 2'd1,
        SRC_LVL = 2'd2,
        SRC_OFF = 2'd3
    } trig_src_e;
endpackage

// File: rtl/ext_pulse_qualifier.sv
// Synchronises the asynchronous trigger pin and accepts an active period only
// after the pin was seen idle and then active for MIN_W consecutive cycles.
// qual_o is a single-cycle strobe.
// Assumes: MIN_W >= 2, clk is free-running.
module ext_pulse_qualifier #(
    parameter int MIN_W = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic fall_sel,
    output logic qual_o
);
    localparam int CW = $clog2(MIN_W + 1);

    logic          sync1, sync2;
    logic          idle_seen;
    logic [CW-1:0] run_cnt;
    logic          active;

    // Two-stage synchroniser for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= pin_async;
            sync2 <= sync1;
        end
    end

    // Apply the selected active polarity.
    always_comb active = fall_sel ? ~sync2 : sync2;

    // Count consecutive active cycles; saturate so one period qualifies once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            idle_seen <= 1'b0;
        end else if (!active) begin
            run_cnt   <= '0;
            idle_seen <= 1'b1;
        end else if (idle_seen && run_cnt < CW'(MIN_W)) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Strobe in the cycle that completes the required width.
    always_comb qual_o = active && idle_seen && (run_cnt == CW'(MIN_W - 1));

    AST_QUAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |=> !qual_o); // R4
    AST_QUAL_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |-> $past(active)); // R4
endmodule

// File: rtl/pattern_matcher.sv
// Registers the digital input bus and compares it with a pattern under a
// per-bit mask (1 = compared). An all-zero mask never matches.
// Assumes: pattern and mask are quasi-static configuration.
module pattern_matcher #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] din,
    input  logic [PW-1:0] pat,
    input  logic [PW-1:0] mask,
    output logic          match_o
);
    logic [PW-1:0] din_q;

    // Capture the input bus once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= '0;
        else        din_q <= din;
    end

    // Masked equality with at least one compared bit.
    always_comb match_o = (|mask) && (((din_q ^ pat) & mask) == '0);

    AST_MATCH_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (mask != '0)); // R6
endmodule

// File: rtl/level_detector.sv
// Compares each tagged sample against the threshold of its channel and
// registers a hit. Each channel has an enable and an above/below polarity;
// comparisons are unsigned and strict.
// Assumes: at most one sample per cycle.
module level_detector #(
    parameter int NCH = 16,
    parameter int DW  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [$clog2(NCH)-1:0] smp_chan,
    input  logic [DW-1:0]    smp_data,
    input  logic [NCH-1:0]   ch_en,
    input  logic [NCH-1:0]   ch_above,
    input  logic [NCH*DW-1:0] ch_thresh,
    output logic             hit_o
);
    localparam int CHW = $clog2(NCH);

    logic [NCH-1:0] ch_hit;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DW-1:0] th;
        // Per-channel threshold compare for the sample currently presented.
        always_comb begin
            th = ch_thresh[c*DW +: DW];
            ch_hit[c] = smp_valid && (smp_chan == CHW'(c)) && ch_en[c] &&
                        (ch_above[c] ? (smp_data > th) : (smp_data < th));
        end
    end

    // Register the combined hit.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_o <= 1'b0;
        else        hit_o <= |ch_hit;
    end

    AST_HIT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(smp_valid)); // R7
    AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(ch_en[smp_chan])); // R7
endmodule

// File: rtl/acq_trigger_unit.sv
// Top of the acquisition trigger unit. Selects one of three trigger sources,
// holds the arm state, and issues one start pulse per arm plus a sticky flag.
// Assumes: src_mode and source configuration are static while armed.
module acq_trigger_unit
    import acq_trig_pkg::*;
#(
    parameter int MIN_W = 50,
    parameter int PW    = 16,
    parameter int NCH   = 16,
    parameter int DW    = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   arm,
    input  logic [1:0]             src_mode,
    input  logic                   ext_fall,
    input  logic                   ext_pin,
    input  logic [PW-1:0]          din,
    input  logic [PW-1:0]          pat_value,
    input  logic [PW-1:0]          pat_mask,
    input  logic                   smp_valid,
    input  logic [$clog2(NCH)-1:0] smp_chan,
    input  logic [DW-1:0]          smp_data,
    input  logic [NCH-1:0]         lvl_enable,
    input  logic [NCH-1:0]         lvl_above,
    input  logic [NCH*DW-1:0]      lvl_thresh,
    output logic                   trig_pulse,
    output logic                   triggered
);
    logic      ext_qual, pat_match, lvl_hit;
    logic      fire;
    logic      armed_q;
    trig_src_e sel;

    ext_pulse_qualifier #(.MIN_W(MIN_W)) u_ext (
        .clk(clk), .rst_n(rst_n), .pin_async(ext_pin),
        .fall_sel(ext_fall), .qual_o(ext_qual)
    );

    pattern_matcher #(.PW(PW)) u_pat (
        .clk(clk), .rst_n(rst_n), .din(din), .pat(pat_value),
        .mask(pat_mask), .match_o(pat_match)
    );

    level_detector #(.NCH(NCH), .DW(DW)) u_lvl (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_data(smp_data), .ch_en(lvl_enable), .ch_above(lvl_above),
        .ch_thresh(lvl_thresh), .hit_o(lvl_hit)
    );

    // Route only the selected source to the fire condition.
    always_comb begin
        sel = trig_src_e'(src_mode);
        unique case (sel)
            SRC_EXT: fire = ext_qual;
            SRC_PAT: fire = pat_match;
            SRC_LVL: fire = lvl_hit;
            default: fire = 1'b0;
        endcase
    end

    // Arm state, single-cycle start pulse and sticky fired flag; arm wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q    <= 1'b0;
            trig_pulse <= 1'b0;
            triggered  <= 1'b0;
        end else if (arm) begin
            armed_q    <= 1'b1;
            trig_pulse <= 1'b0;
            triggered  <= 1'b0;
        end else if (armed_q && fire) begin
            armed_q    <= 1'b0;
            trig_pulse <= 1'b1;
            triggered  <= 1'b1;
        end else begin
            trig_pulse <= 1'b0;
        end
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse); // R2
    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> triggered); // R2
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !arm) |=> triggered); // R2
    AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(armed_q && !arm)); // R2
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(src_mode == 2'd3) |-> !trig_pulse); // R8
endmodule

// File: tb/acq_trigger_unit_test.sv
module acq_trigger_unit_test;
    localparam int CLK_PERIOD = 20;
    localparam int MIN_W = 50;
    localparam int NCH = 16;
    localparam int DW = 16;

    logic clk = 0, rst_n = 0, arm = 0, ext_fall = 0, ext_pin = 0, smp_valid = 0;
    logic [1:0] src_mode = 0;
    logic [15:0] din = 0, pat_value = 0, pat_mask = 0, smp_data = 0;
    logic [3:0] smp_chan = 0;
    logic [NCH-1:0] lvl_enable = 0, lvl_above = 0;
    logic [DW-1:0] thr [NCH];
    logic [NCH*DW-1:0] thr_flat;
    logic trig_pulse, triggered;

    int vectors = 0, miscompares = 0;
    int neg_cnt = 0, pulse_count = 0, last_pulse_at = -1;
    string cur_req = "R1";

    // model state
    bit m_armed = 0, m_pulse = 0, m_flag = 0, din_lvl_prev = 0;
    logic [15:0] din_prev = 0;
    bit hist[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb for (int i = 0; i < NCH; i++) thr_flat[i*DW +: DW] = thr[i];

    acq_trigger_unit #(.MIN_W(MIN_W)) uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .src_mode(src_mode),
        .ext_fall(ext_fall), .ext_pin(ext_pin), .din(din),
        .pat_value(pat_value), .pat_mask(pat_mask), .smp_valid(smp_valid),
        .smp_chan(smp_chan), .smp_data(smp_data), .lvl_enable(lvl_enable),
        .lvl_above(lvl_above), .lvl_thresh(thr_flat),
        .trig_pulse(trig_pulse), .triggered(triggered)
    );

    function automatic bit is_act(bit v);
        return ext_fall ? !v : v;
    endfunction

    function automatic bit ext_fire_m();
        int n = hist.size();
        if (n < MIN_W + 2) return 0;
        for (int k = 1; k <= MIN_W; k++) if (!is_act(hist[n-1-k])) return 0;
        return !is_act(hist[n-2-MIN_W]);
    endfunction

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        bit f;
        if (!rst_n) begin
            m_armed = 0; m_pulse = 0; m_flag = 0;
            hist.delete(); din_prev = 0; din_lvl_prev = 0;
        end else begin
            case (src_mode)
                2'd0: f = ext_fire_m();
                2'd1: f = (pat_mask != 0) && (((din_prev ^ pat_value) & pat_mask) == 0);
                2'd2: f = din_lvl_prev;
                default: f = 0;
            endcase
            if (arm) begin m_armed = 1; m_flag = 0; m_pulse = 0; end
            else if (m_armed && f) begin m_armed = 0; m_pulse = 1; m_flag = 1; end
            else m_pulse = 0;
            hist.push_back(ext_pin);
            if (hist.size() > MIN_W + 3) void'(hist.pop_front());
            din_prev = din;
            din_lvl_prev = smp_valid && lvl_enable[smp_chan] &&
                (lvl_above[smp_chan] ? (smp_data > thr[smp_chan]) : (smp_data < thr[smp_chan]));
        end
    end

    // Compare outputs against the model away from the active edge.
    always @(negedge clk) begin
        neg_cnt++;
        if (trig_pulse) begin pulse_count++; last_pulse_at = neg_cnt; end
        vectors++;
        if (trig_pulse !== m_pulse || triggered !== m_flag) begin
            miscompares++;
            $display("FAIL %s cycle %0d: pulse/flag actual %b%b expected %b%b",
                     cur_req, neg_cnt, trig_pulse, triggered, m_pulse, m_flag);
        end
    end

    task automatic step(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_arm();
        arm = 1; step(1); arm = 0;
    endtask

    // Hold the pin active for w cycles, return to idle, let the pipeline drain.
    task automatic ext_burst(int w, output int t0);
        ext_pin = !ext_fall; t0 = neg_cnt;
        step(w);
        ext_pin = ext_fall;
        step(6);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int t0, pc;
        for (int i = 0; i < NCH; i++) thr[i] = 0;
        step(4);
        chk(trig_pulse == 0 && triggered == 0, "R1 reset", {trig_pulse, triggered}, 0);
        rst_n = 1; step(MIN_W + 5);
        chk(triggered == 0, "R1 unarmed after reset", triggered, 0);

        // R3/R5: rising edge, full width
        cur_req = "R5";
        do_arm(); step(2);
        pc = pulse_count;
        ext_burst(MIN_W + 10, t0);
        chk(pulse_count == pc + 1, "R3 rising fires once", pulse_count - pc, 1);
        chk(last_pulse_at - t0 == MIN_W + 2, "R5 latency", last_pulse_at - t0, MIN_W + 2);
        chk(triggered == 1, "R2 flag held", triggered, 1);

        // R4: one cycle short, then exact width
        cur_req = "R4";
        do_arm(); step(3);
        pc = pulse_count;
        ext_burst(MIN_W - 1, t0);
        chk(pulse_count == pc, "R4 short pulse ignored", pulse_count - pc, 0);
        chk(triggered == 0, "R4 flag stays clear", triggered, 0);
        ext_burst(MIN_W, t0);
        chk(pulse_count == pc + 1, "R4 exact width accepted", pulse_count - pc, 1);

        // R3: falling polarity
        cur_req = "R3";
        ext_pin = 1; step(MIN_W + 10);
        ext_fall = 1; step(5);
        do_arm(); step(2);
        pc = pulse_count;
        ext_burst(MIN_W + 5, t0);
        chk(pulse_count == pc + 1, "R3 falling fires", pulse_count - pc, 1);
        chk(last_pulse_at - t0 == MIN_W + 2, "R3 falling latency", last_pulse_at - t0, MIN_W + 2);

        // R2: no second fire without re-arm
        cur_req = "R2";
        pc = pulse_count;
        ext_burst(MIN_W + 5, t0);
        chk(pulse_count == pc, "R2 one fire per arm", pulse_count - pc, 0);
        chk(triggered == 1, "R2 flag sticky", triggered, 1);

        // R6: masked pattern
        cur_req = "R6";
        src_mode = 2'd1; pat_mask = 16'h00FF; pat_value = 16'h123C; din = 16'h0000;
        do_arm(); step(5);
        chk(triggered == 0, "R6 no match", triggered, 0);
        pc = pulse_count;
        din = 16'hA53C; t0 = neg_cnt; step(5);
        chk(pulse_count == pc + 1 && last_pulse_at - t0 == 2, "R6 masked match latency",
            last_pulse_at - t0, 2);
        pat_mask = 16'h0000; din = 16'h0000; do_arm(); step(3);
        din = 16'h1234; step(6);
        chk(triggered == 0, "R6 zero mask never matches", triggered, 0);
        pat_mask = 16'hFFFF; pat_value = 16'h1234; step(4);
        chk(triggered == 1, "R6 full mask match", triggered, 1);
        // arm while match present: arm wins, fires after
        do_arm(); step(4);
        chk(triggered == 1, "R2 re-fire after arm with standing match", triggered, 1);

        // R7: level mode
        cur_req = "R7";
        src_mode = 2'd2; din = 0;
        thr[3] = 16'h8000; lvl_above[3] = 1; lvl_enable[3] = 1;
        thr[9] = 16'h0100; lvl_above[9] = 0; lvl_enable[9] = 1;
        thr[5] = 16'h0000; lvl_above[5] = 1; lvl_enable[5] = 0;
        do_arm(); step(2);
        smp_valid = 1; smp_chan = 5; smp_data = 16'hFFFF; step(1);
        smp_chan = 3; smp_data = 16'h8000; step(1);
        smp_valid = 0; smp_data = 16'hFFFF; step(4);
        chk(triggered == 0, "R7 disabled/equal/invalid ignored", triggered, 0);
        pc = pulse_count;
        smp_valid = 1; smp_chan = 3; smp_data = 16'h8001; t0 = neg_cnt; step(1);
        smp_valid = 0; step(4);
        chk(pulse_count == pc + 1 && last_pulse_at - t0 == 2, "R7 above latency",
            last_pulse_at - t0, 2);
        do_arm(); step(2);
        smp_valid = 1; smp_chan = 9; smp_data = 16'h0100; step(1);
        smp_valid = 0; step(3);
        chk(triggered == 0, "R7 below equal ignored", triggered, 0);
        smp_valid = 1; smp_data = 16'h00FF; step(1);
        smp_valid = 0; step(3);
        chk(triggered == 1, "R7 below fires", triggered, 1);

        // R8: source selection
        cur_req = "R8";
        src_mode = 2'd1; pat_mask = 16'hFFFF; pat_value = 16'hFFFF; din = 0;
        ext_fall = 0; ext_pin = 0; step(5);
        do_arm(); step(2);
        ext_burst(MIN_W + 5, t0);
        chk(triggered == 0, "R8 ext ignored in pattern mode", triggered, 0);
        src_mode = 2'd3; din = 16'hFFFF; step(2);
        ext_burst(MIN_W + 5, t0);
        smp_valid = 1; smp_chan = 3; smp_data = 16'hFFFF; step(1); smp_valid = 0;
        step(4);
        chk(triggered == 0, "R8 off mode silent", triggered, 0);

        step(5);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule